// File: doc/BRIEF.md
# Four-Byte Graphics Cache with Multiply-Accumulate Write-Out

This block holds a 32-bit graphics cache as four byte lanes and turns data-port traffic into write requests for a video memory that is four bytes wide. When the data port reads with cache fill enabled, the byte returned from memory is loaded into the cache. In 8-bit mode a whole byte is loaded. In 4-bit mode a single nibble is loaded, so two reads fill one cache byte. A byte index and a nibble index walk through the four lanes.

When the data port writes, the block produces a registered write request. With cache write off, this is an ordinary single-byte write at the CPU address. With cache write on, it is an aligned 4-byte word with a 2-bit keep mask per byte, where a set bit preserves that nibble in memory. The word carries one of three things: the cache contents, the result of a signed 16×16 multiply added to or subtracted from a 32-bit accumulator, or one byte replicated across all lanes. The mask comes either from the CPU data byte or, in transparent mode, from which nibbles or bytes of the outgoing data are zero.

The memory itself, address auto-increment and the register file that holds the mode bits are outside the block. The mode bits arrive as plain inputs.

Top module: `gcache_top`

## Requirements
- R1: After reset the cache bytes, byte index, nibble index and accumulator are all zero, and `vw_en` is low.
- R2: In 4-bit fill mode the nibble taken from `fill_data` is bits [3:0] when `fill_nib` is 1 and bits [7:4] when `fill_nib` is 0.
- R3: A 4-bit fill with nibble index 0 writes bits [7:4] of cache byte `byte_idx` and sets the nibble index to 1. A 4-bit fill with nibble index 1 writes bits [3:0], clears the nibble index and advances the byte index modulo 4. An 8-bit fill writes the whole byte, advances the byte index and leaves the nibble index unchanged. `fill_restart` clears both indices, and takes priority over a fill in the same cycle.
- R4: The MAC value is acc + P, or acc − P when `sub_en` is 1, modulo 2^32, where P = signed {cache1,cache0} × signed {cache3,cache2}. `acc_step` loads the MAC value into the accumulator. `acc_clear` zeroes the accumulator and takes priority over `acc_step`.
- R5: A write with `cache_wr_en` at 1 is issued with `vw_word`=1 and with bits [1:0] of the address cleared.
- R6: For a word write with `cycle_en` at 0, lane k (`vw_data[8k+7:8k]`) carries cache byte k, or byte k of the MAC value when `mult_en` is 1.
- R7: Every other write carries a single byte replicated in all four lanes: cache byte `byte_idx` when `cycle_en` is 1, or `wr_data` when `cycle_en` is 0.
- R8: For a word write with `trans_en` at 0, the mask of lane k (`vw_mask[2k+1:2k]`) is `wr_data[2k+1:2k]`.
- R9: For a word write with `trans_en` at 1 in 4-bit mode, mask bit 2k+1 is set when the high nibble of lane k is zero, and mask bit 2k is set when the low nibble of lane k is zero.
- R10: For a word write with `trans_en` at 1 in 8-bit mode, the mask of lane k is 3 when lane k is zero and 0 otherwise.
- R11: A write with `cache_wr_en` at 0 is issued with `vw_word`=0, the unaligned address, a zero mask, and `vw_nib` equal to `wr_nib`.
- R12: The write bus is registered. `vw_en` is high exactly one cycle after `wr_en` is high. The write uses the cache, index and accumulator values from before any fill or accumulator update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fill_en | input | 1 | Data-port read with cache fill enabled |
| fill_restart | input | 1 | Clear the byte index and the nibble index |
| fill_data | input | 8 | Byte read from video memory |
| fill_nib | input | 1 | Nibble address bit of the read |
| nib_mode | input | 1 | 1 selects 4-bit fill and 4-bit transparency |
| cache_wr_en | input | 1 | Issue writes as aligned 4-byte words |
| cycle_en | input | 1 | Byte cycling: replicate cache byte `byte_idx` |
| mult_en | input | 1 | Word writes carry the MAC value |
| sub_en | input | 1 | MAC subtracts the product |
| trans_en | input | 1 | Derive masks from zero data |
| acc_clear | input | 1 | Zero the accumulator |
| acc_step | input | 1 | Load the MAC value into the accumulator |
| wr_en | input | 1 | Data-port write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | CPU write byte |
| wr_nib | input | 1 | Nibble address bit of the write |
| vw_en | output | 1 | Write request valid |
| vw_word | output | 1 | 1 for an aligned 4-byte word write |
| vw_addr | output | ADDR_W | Write address |
| vw_data | output | 32 | Write data, lane 0 in bits [7:0] |
| vw_mask | output | 8 | Keep mask, 2 bits per lane, a set bit preserves that nibble |
| vw_nib | output | 1 | Nibble address bit for a single-byte write |

## Verification
A cache, index or accumulator that has gone wrong stays hidden until the next write that exposes it, and then shows up one cycle after that write. A wrong cache byte or a wrong accumulator shows in the lanes of a word write, or in a MAC word write. A wrong byte index shows as the wrong replicated byte in cycling mode, or as the wrong lane filled on the next fill. A wrong nibble index puts a nibble in the wrong half of a byte, and this appears on the first word write after the fill. For that reason the stimulus mixes fills, accumulator steps and exposing writes densely, so that each fault is seen within a few cycles of its cause.

// File: rtl/gcache_pkg.sv
package gcache_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;
  localparam int unsigned MASK_W = 2 * LANES;
  localparam int unsigned IDX_W  = $clog2(LANES);

  typedef logic [LANES-1:0][BYTE_W-1:0] cache_t;

  // keep mask for one lane in transparent mode
  function automatic logic [1:0] zero_mask(input logic [BYTE_W-1:0] b, input logic nib);
    if (nib) zero_mask = {(b[7:4] == 4'h0), (b[3:0] == 4'h0)};
    else     zero_mask = (b == '0) ? 2'b11 : 2'b00;
  endfunction

  function automatic logic pairs_full_or_empty(input logic [MASK_W-1:0] m);
    pairs_full_or_empty = 1'b1;
    for (int k = 0; k < LANES; k++)
      if (m[2*k +: 2] == 2'b01 || m[2*k +: 2] == 2'b10) pairs_full_or_empty = 1'b0;
  endfunction
endpackage

// File: rtl/gcache_fill.sv
module gcache_fill
  import gcache_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic               fill_restart,
  input  logic [BYTE_W-1:0]  fill_data,
  input  logic               fill_nib,
  input  logic               nib_mode,
  output cache_t             cache_q,
  output logic [IDX_W-1:0]   byte_idx_q
);
  cache_t           cache_d;
  logic [IDX_W-1:0] idx_d;
  logic             nib_q, nib_d;
  logic [3:0]       sel_nib;
  logic [IDX_W-1:0] idx_inc;

  assign sel_nib = fill_nib ? fill_data[3:0] : fill_data[7:4];
  assign idx_inc = (byte_idx_q == IDX_W'(LANES-1)) ? '0 : byte_idx_q + IDX_W'(1);

  always_comb begin
    cache_d = cache_q;
    idx_d   = byte_idx_q;
    nib_d   = nib_q;
    if (fill_restart) begin
      idx_d = '0;
      nib_d = 1'b0;
    end else if (fill_en) begin
      if (nib_mode) begin
        if (!nib_q) begin
          cache_d[byte_idx_q][7:4] = sel_nib;
          nib_d = 1'b1;
        end else begin
          cache_d[byte_idx_q][3:0] = sel_nib;
          nib_d = 1'b0;
          idx_d = idx_inc;
        end
      end else begin
        cache_d[byte_idx_q] = fill_data;
        idx_d = idx_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_q    <= '0;
      byte_idx_q <= '0;
      nib_q      <= 1'b0;
    end else if (fill_en || fill_restart) begin
      cache_q    <= cache_d;
      byte_idx_q <= idx_d;
      nib_q      <= nib_d;
    end
  end

  // R3: first nibble of a pair keeps the byte index and sets the nibble index
  a_r3_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_restart && nib_mode && !nib_q) |=> (nib_q && $stable(byte_idx_q)));
  // R3: second nibble advances the byte index
  a_r3_second_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_restart && nib_mode && nib_q) |=>
      (!nib_q && byte_idx_q == IDX_W'($past(byte_idx_q) + 1'b1)));
  // R3: restart clears both indices
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fill_restart |=> (byte_idx_q == '0 && !nib_q));
  // R2: upper nibble written from the selected half of the read byte
  a_r2_nibble_select: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_restart && nib_mode && !nib_q && byte_idx_q == '0) |=>
      (cache_q[0][7:4] == ($past(fill_nib) ? $past(fill_data[3:0]) : $past(fill_data[7:4]))));
endmodule

// File: rtl/gcache_mac.sv
module gcache_mac
  import gcache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cache_t            cache_q,
  input  logic              sub_en,
  input  logic              acc_clear,
  input  logic              acc_step,
  output logic [WORD_W-1:0] mac_val
);
  logic [WORD_W-1:0]        acc_q, acc_d;
  logic signed [15:0]       op_a, op_b;
  logic signed [WORD_W-1:0] prod;

  assign op_a = {cache_q[1], cache_q[0]};
  assign op_b = {cache_q[3], cache_q[2]};
  assign prod = op_a * op_b;

  always_comb begin
    mac_val = sub_en ? (acc_q - WORD_W'(prod)) : (acc_q + WORD_W'(prod));
    acc_d   = acc_clear ? '0 : mac_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     acc_q <= '0;
    else if (acc_clear || acc_step) acc_q <= acc_d;
  end

  // R4: clear wins and zeroes the accumulator
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |=> (acc_q == '0));
  // R4: accumulator holds when neither control is active
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clear && !acc_step) |=> $stable(acc_q));
endmodule

// File: rtl/gcache_wrgen.sv
module gcache_wrgen
  import gcache_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cache_t            cache_q,
  input  logic [IDX_W-1:0]  byte_idx_q,
  input  logic [WORD_W-1:0] mac_val,
  input  logic              nib_mode,
  input  logic              cache_wr_en,
  input  logic              cycle_en,
  input  logic              mult_en,
  input  logic              trans_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_nib,
  output logic              vw_en,
  output logic              vw_word,
  output logic [ADDR_W-1:0] vw_addr,
  output logic [WORD_W-1:0] vw_data,
  output logic [MASK_W-1:0] vw_mask,
  output logic              vw_nib
);
  logic [BYTE_W-1:0] solo;
  cache_t            lanes_d;
  logic [MASK_W-1:0] mask_d;
  logic [ADDR_W-1:0] addr_d;

  assign solo   = cycle_en ? cache_q[byte_idx_q] : wr_data;
  assign addr_d = cache_wr_en ? {wr_addr[ADDR_W-1:2], 2'b00} : wr_addr;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (cache_wr_en && !cycle_en)
        lanes_d[k] = mult_en ? mac_val[k*BYTE_W +: BYTE_W] : cache_q[k];
      else
        lanes_d[k] = solo;
      if (!cache_wr_en)  mask_d[2*k +: 2] = 2'b00;
      else if (trans_en) mask_d[2*k +: 2] = zero_mask(lanes_d[k], nib_mode);
      else               mask_d[2*k +: 2] = wr_data[2*k +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vw_en <= 1'b0;
    else        vw_en <= wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vw_word <= 1'b0;
      vw_addr <= '0;
      vw_data <= '0;
      vw_mask <= '0;
      vw_nib  <= 1'b0;
    end else if (wr_en) begin
      vw_word <= cache_wr_en;
      vw_addr <= addr_d;
      vw_data <= lanes_d;
      vw_mask <= mask_d;
      vw_nib  <= wr_nib;
    end
  end

  // R5: word writes are aligned
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (vw_en && vw_word) |-> (vw_addr[1:0] == 2'b00));
  // R11: single-byte writes carry no mask
  a_r11_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (vw_en && !vw_word) |-> (vw_mask == '0));
  // R12: one-cycle registered request
  a_r12_issue: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vw_en);
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !vw_en);
  // R7: replicated writes carry one byte in all lanes
  a_r7_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (!cache_wr_en || cycle_en)) |=>
      (vw_data[15:8] == vw_data[7:0] && vw_data[23:16] == vw_data[7:0] && vw_data[31:24] == vw_data[7:0]));
  // R10: byte transparency masks whole lanes only
  a_r10_whole_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cache_wr_en && trans_en && !nib_mode) |=> pairs_full_or_empty(vw_mask));
endmodule

// File: rtl/gcache_top.sv
module gcache_top
  import gcache_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic              fill_restart,
  input  logic [7:0]        fill_data,
  input  logic              fill_nib,
  input  logic              nib_mode,
  input  logic              cache_wr_en,
  input  logic              cycle_en,
  input  logic              mult_en,
  input  logic              sub_en,
  input  logic              trans_en,
  input  logic              acc_clear,
  input  logic              acc_step,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_nib,
  output logic              vw_en,
  output logic              vw_word,
  output logic [ADDR_W-1:0] vw_addr,
  output logic [31:0]       vw_data,
  output logic [7:0]        vw_mask,
  output logic              vw_nib
);
  logic             rst_meta_q, rst_sync_q;
  cache_t           cache_q;
  logic [IDX_W-1:0] byte_idx_q;
  logic [WORD_W-1:0] mac_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gcache_fill u_fill (
    .clk(clk), .rst_n(rst_sync_q), .fill_en(fill_en), .fill_restart(fill_restart),
    .fill_data(fill_data), .fill_nib(fill_nib), .nib_mode(nib_mode),
    .cache_q(cache_q), .byte_idx_q(byte_idx_q)
  );

  gcache_mac u_mac (
    .clk(clk), .rst_n(rst_sync_q), .cache_q(cache_q), .sub_en(sub_en),
    .acc_clear(acc_clear), .acc_step(acc_step), .mac_val(mac_val)
  );

  gcache_wrgen #(.ADDR_W(ADDR_W)) u_wrgen (
    .clk(clk), .rst_n(rst_sync_q), .cache_q(cache_q), .byte_idx_q(byte_idx_q),
    .mac_val(mac_val), .nib_mode(nib_mode), .cache_wr_en(cache_wr_en),
    .cycle_en(cycle_en), .mult_en(mult_en), .trans_en(trans_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_nib(wr_nib),
    .vw_en(vw_en), .vw_word(vw_word), .vw_addr(vw_addr), .vw_data(vw_data),
    .vw_mask(vw_mask), .vw_nib(vw_nib)
  );
endmodule

// File: tb/gcache_top_tb.sv
module gcache_top_tb;
  localparam int AW = 17;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_en, fill_restart, fill_nib, nib_mode, cache_wr_en, cycle_en;
  logic mult_en, sub_en, trans_en, acc_clear, acc_step, wr_en, wr_nib;
  logic [7:0] fill_data, wr_data;
  logic [AW-1:0] wr_addr;
  logic vw_en, vw_word, vw_nib;
  logic [AW-1:0] vw_addr;
  logic [31:0] vw_data;
  logic [7:0] vw_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  m_cache [4];
  logic [1:0]  m_idx;
  logic        m_nib;
  logic [31:0] m_acc;

  always #5 clk = ~clk;

  gcache_top #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_restart(fill_restart),
    .fill_data(fill_data), .fill_nib(fill_nib), .nib_mode(nib_mode),
    .cache_wr_en(cache_wr_en), .cycle_en(cycle_en), .mult_en(mult_en),
    .sub_en(sub_en), .trans_en(trans_en), .acc_clear(acc_clear), .acc_step(acc_step),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_nib(wr_nib),
    .vw_en(vw_en), .vw_word(vw_word), .vw_addr(vw_addr), .vw_data(vw_data),
    .vw_mask(vw_mask), .vw_nib(vw_nib)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mac_f();
    logic signed [15:0] a, b;
    logic signed [31:0] p;
    a = {m_cache[1], m_cache[0]};
    b = {m_cache[3], m_cache[2]};
    p = a * b;
    return sub_en ? m_acc - p : m_acc + p;
  endfunction

  function automatic logic [1:0] lane_mask(input logic [7:0] b, input int k);
    if (!cache_wr_en) return 2'b00;
    if (!trans_en)    return wr_data[2*k +: 2];
    if (nib_mode)     return {b[7:4] == 4'h0, b[3:0] == 4'h0};
    return (b == 8'h00) ? 2'b11 : 2'b00;
  endfunction

  task automatic idle();
    fill_en = 0; fill_restart = 0; fill_data = 0; fill_nib = 0; nib_mode = 0;
    cache_wr_en = 0; cycle_en = 0; mult_en = 0; sub_en = 0; trans_en = 0;
    acc_clear = 0; acc_step = 0; wr_en = 0; wr_addr = 0; wr_data = 0; wr_nib = 0;
  endtask

  // one clock: expectations from model state before the edge, checked after it
  task automatic tick(input string dtag = "");
    logic [31:0] e_data, mv;
    logic [7:0]  e_mask, solo, ln;
    logic [AW-1:0] e_addr;
    string tg_d, tg_m, tg_a;
    logic [3:0] sn;
    mv = mac_f();
    solo = cycle_en ? m_cache[m_idx] : wr_data;
    for (int k = 0; k < 4; k++) begin
      ln = (cache_wr_en && !cycle_en) ? (mult_en ? mv[8*k +: 8] : m_cache[k]) : solo;
      e_data[8*k +: 8] = ln;
      e_mask[2*k +: 2] = lane_mask(ln, k);
    end
    e_addr = cache_wr_en ? {wr_addr[AW-1:2], 2'b00} : wr_addr;
    tg_d = (dtag != "") ? dtag : (!cache_wr_en || cycle_en) ? "R7" : mult_en ? "R4" : "R6";
    tg_m = !cache_wr_en ? "R11" : !trans_en ? "R8" : nib_mode ? "R9" : "R10";
    tg_a = cache_wr_en ? "R5" : "R11";
    // model update
    if (acc_clear) m_acc = 0; else if (acc_step) m_acc = mv;
    if (fill_restart) begin
      m_idx = 0; m_nib = 0;
    end else if (fill_en) begin
      if (nib_mode) begin
        sn = fill_nib ? fill_data[3:0] : fill_data[7:4];
        if (!m_nib) begin m_cache[m_idx][7:4] = sn; m_nib = 1; end
        else begin m_cache[m_idx][3:0] = sn; m_nib = 0; m_idx = m_idx + 2'd1; end
      end else begin
        m_cache[m_idx] = fill_data; m_idx = m_idx + 2'd1;
      end
    end
    @(posedge clk); #1;
    if (wr_en) begin
      chk("R12", {31'd0, vw_en}, 32'd1);
      chk(tg_a, {31'd0, vw_word}, {31'd0, cache_wr_en});
      chk(tg_a, {15'd0, vw_addr}, {15'd0, e_addr});
      chk(tg_d, vw_data, e_data);
      chk(tg_m, {24'd0, vw_mask}, {24'd0, e_mask});
      if (!cache_wr_en) chk("R11", {31'd0, vw_nib}, {31'd0, wr_nib});
    end else begin
      chk("R12", {31'd0, vw_en}, 32'd0);
    end
  endtask

  task automatic fill(input logic [7:0] d, input logic nb, input logic nm);
    idle(); fill_en = 1; fill_data = d; fill_nib = nb; nib_mode = nm; tick();
  endtask

  task automatic wword(input string tg, input logic m, input logic s);
    idle(); wr_en = 1; cache_wr_en = 1; mult_en = m; sub_en = s;
    wr_addr = 17'h1_2347; wr_data = 8'h00; tick(tg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240923));
    idle();
    for (int k = 0; k < 4; k++) m_cache[k] = 0;
    m_idx = 0; m_nib = 0; m_acc = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1", {31'd0, vw_en}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: cache and accumulator are zero: word write and MAC write show zero
    idle(); wr_en = 1; cache_wr_en = 1; wr_addr = 17'h0_0003; wr_data = 8'hE4; tick("R1");
    idle(); wr_en = 1; cache_wr_en = 1; mult_en = 1; tick("R1");
    // R2/R3: nibble fills into lane 0 then lane 1
    fill(8'hA5, 1'b0, 1'b1); // high nibble A into cache0[7:4]
    fill(8'h3C, 1'b1, 1'b1); // low nibble C into cache0[3:0]
    fill(8'h7E, 1'b1, 1'b1); // E into cache1[7:4]
    fill(8'h91, 1'b0, 1'b1); // 9 into cache1[3:0]
    wword("R2", 0, 0);
    chk("R3", vw_data, 32'h0000_E9AC);
    // R3: 8-bit fill, then restart and overwrite lane 0
    fill(8'hFF, 1'b0, 1'b0);
    fill(8'h80, 1'b0, 1'b0);
    idle(); fill_restart = 1; fill_en = 1; fill_data = 8'h55; tick();
    fill(8'h12, 1'b0, 1'b0);
    wword("R3", 0, 0);
    chk("R3", vw_data, 32'h80FF_E912);
    // R4: MAC with negative operand, subtract, accumulate, clear
    idle(); acc_step = 1; tick();
    wword("R4", 1, 0);
    wword("R4", 1, 1);
    idle(); acc_clear = 1; acc_step = 1; tick();
    wword("R4", 1, 0);
    // R7: byte cycling replicates cache byte at index
    idle(); wr_en = 1; cycle_en = 1; wr_data = 8'h33; wr_addr = 17'h0_0101; tick("R7");
    idle(); wr_en = 1; cycle_en = 1; cache_wr_en = 1; wr_data = 8'h33; tick("R7");
    // R9/R10: transparency with zero nibbles and bytes
    idle(); wr_en = 1; cache_wr_en = 1; cycle_en = 1; trans_en = 1; nib_mode = 1; tick("R9");
    idle(); wr_en = 1; cache_wr_en = 1; trans_en = 1; wr_data = 8'h00; tick("R10");
    idle(); wr_en = 1; cache_wr_en = 1; trans_en = 1; nib_mode = 1; wr_data = 8'h00; tick("R9");
    // R12: write and fill in the same cycle use the old cache
    idle(); wr_en = 1; cache_wr_en = 1; fill_en = 1; fill_data = 8'hC3; tick("R12");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      idle();
      fill_en = ($urandom % 3) == 0;
      fill_restart = ($urandom % 23) == 0;
      fill_data = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      if ($urandom % 4 == 0) fill_data[7:4] = 4'h0;
      fill_nib = 1'($urandom); nib_mode = 1'($urandom);
      cache_wr_en = 1'($urandom); cycle_en = ($urandom % 3) == 0;
      mult_en = 1'($urandom); sub_en = 1'($urandom); trans_en = 1'($urandom);
      acc_clear = ($urandom % 17) == 0; acc_step = ($urandom % 4) == 0;
      wr_en = ($urandom % 4) != 0;
      wr_addr = AW'($urandom); wr_data = 8'($urandom); wr_nib = 1'($urandom);
      tick();
    end
    idle(); tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule